// File: doc/BRIEF.md
# I2C Transaction Retry Controller

This block sits between a command source and a bit-level I2C master engine. It takes one transaction request, starts the engine, and reads the engine's completion status. If the attempt fails with a NACK or a clock-stretch timeout, it does not report an error straight away. It waits a programmable back-off and starts the engine again. It repeats this until an attempt succeeds or the configured attempt limit is used up.

When the limit is reached and escalation is enabled, the controller pulses a bus-recovery request before it reports. The recovery sequence itself runs elsewhere. The back-off is a counter inside the controller, so the command source and every other piece of logic keep running while a retry is pending. A saturating event counter records each retry and each recovery request for diagnostics. Software can read this counter at any time and clear it.

The attempt limit, the back-off length and the escalation enable are captured when a request is accepted. They stay fixed for the whole sequence.

Top module: `xfer_retry_ctl`

## Requirements
- R1: After reset the outputs are: `req_ready` 1, `eng_start` 0, `done` 0, `recover_req` 0, `final_status` 0, `attempts` 0 and `evt_count` 0.
- R2: A request accepted while `req_ready` is 1 drives `eng_start` high for exactly one cycle, in the cycle after acceptance. `req_ready` then stays low until the cycle after `done`.
- R3: An engine completion with status 2'b00 (ok) ends the sequence at once. `done` pulses for one cycle, in the cycle after `eng_done`, with `final_status` 2'b00. `recover_req` stays low.
- R4: Any non-zero completion status counts as a retryable failure: 2'b01 is a NACK, 2'b10 is a timeout. If the limit is not yet reached, the next `eng_start` comes exactly B+2 cycles after the `eng_done` cycle, where B is the captured `backoff_cycles`.
- R5: The attempt limit is the captured `max_attempts`, and a value of 0 is taken as 1. After that many failed attempts no further `eng_start` is issued. `final_status` then holds the last failure code. `attempts` counts the engine starts of the current request and holds its value until the next request is accepted.
- R6: On the final failure with the captured `recover_en` at 1, `recover_req` pulses for one cycle in the cycle after `eng_done`, and `done` follows in the next cycle. With `recover_en` at 0, `done` comes in the cycle after `eng_done` and no recovery request is made.
- R7: `evt_count` goes up by one for each retry (each entry into back-off) and for each recovery request. It saturates at 2^EW-1.
- R8: While `evt_clr` is high, `evt_count` becomes 0 in the next cycle. A clear wins over a simultaneous increment.
- R9: A request made while `req_ready` is 0 is refused. It starts no engine cycle and does not change `attempts`.
- R10: An `eng_done` pulse while the controller is not waiting for the engine is ignored. It changes neither `done` nor `final_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | High when idle and able to accept a request |
| max_attempts | input | AW | Attempt limit, captured on accept (0 means 1) |
| backoff_cycles | input | BW | Back-off length B, captured on accept |
| recover_en | input | 1 | Escalate to bus recovery on persistent failure, captured on accept |
| eng_start | output | 1 | One-cycle start pulse to the master engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_status | input | 2 | Completion code: 00 ok, 01 NACK, 10 timeout, 11 other failure |
| done | output | 1 | One-cycle end-of-sequence pulse |
| final_status | output | 2 | Code of the last completion of the sequence |
| attempts | output | AW | Number of engine starts for the current request |
| recover_req | output | 1 | One-cycle bus-recovery request |
| evt_clr | input | 1 | Clears the event counter |
| evt_count | output | EW | Saturating count of retries and recovery requests |

## Verification
The bench builds the controller with AW=3, BW=4 and EW=3. The 3-bit event counter reaches its saturation value of 7 after only a handful of failing sequences, so the hold at saturation is exercised. The 4-bit back-off keeps the retry gaps short, and sequences with B=0 and B=2 are run. A 3-bit attempt width allows limits of 1 and 3 as well as the zero-means-one case. This lets the bench run success on the first attempt, success after one retry, exhaustion with and without escalation, refused busy requests and stray completions, each against a cycle model.

// File: rtl/xfer_retry_ctl.sv
module xfer_retry_ctl #(
  parameter int AW = 3,
  parameter int BW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] max_attempts,
  input  logic [BW-1:0] backoff_cycles,
  input  logic          recover_en,
  output logic          eng_start,
  input  logic          eng_done,
  input  logic [1:0]    eng_status,
  output logic          done,
  output logic [1:0]    final_status,
  output logic [AW-1:0] attempts,
  output logic          recover_req,
  input  logic          evt_clr,
  output logic [EW-1:0] evt_count
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_BACK, S_RECOV, S_REPORT
  } st_t;

  st_t           st;
  logic [AW-1:0] att, lim;
  logic [BW-1:0] bo, bo_len;
  logic          rec_q;
  logic [1:0]    fstat;
  logic [EW-1:0] evt;

  wire fail  = eng_status != 2'b00;
  wire last  = att >= lim;
  wire retry = (st == S_WAIT) && eng_done && fail && !last;
  wire bump  = retry || (st == S_RECOV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      att    <= '0;
      lim    <= AW'(1);
      bo     <= '0;
      bo_len <= '0;
      rec_q  <= 1'b0;
      fstat  <= 2'b00;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            att    <= '0;
            lim    <= (max_attempts == '0) ? AW'(1) : max_attempts;
            bo_len <= backoff_cycles;
            rec_q  <= recover_en;
            st     <= S_ISSUE;
          end
        S_ISSUE: begin
          att <= att + AW'(1);
          st  <= S_WAIT;
        end
        S_WAIT:
          if (eng_done) begin
            fstat <= eng_status;
            if (!fail)
              st <= S_REPORT;
            else if (last)
              st <= rec_q ? S_RECOV : S_REPORT;
            else begin
              bo <= bo_len;
              st <= S_BACK;
            end
          end
        S_BACK:
          if (bo == '0) st <= S_ISSUE;
          else          bo <= bo - BW'(1);
        S_RECOV:  st <= S_REPORT;
        S_REPORT: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || evt_clr)
      evt <= '0;
    else if (bump && evt != {EW{1'b1}})
      evt <= evt + EW'(1);
  end

  assign req_ready    = st == S_IDLE;
  assign eng_start    = st == S_ISSUE;
  assign done         = st == S_REPORT;
  assign recover_req  = st == S_RECOV;
  assign final_status = fstat;
  assign attempts     = att;
  assign evt_count    = evt;

endmodule

module xfer_retry_ctl_chk #(
  parameter int AW = 3,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          eng_start,
  input logic          done,
  input logic          recover_req,
  input logic [1:0]    final_status,
  input logic [AW-1:0] attempts,
  input logic          evt_clr,
  input logic [EW-1:0] evt_count
);

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !req_ready);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  p_recover_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |=> done);

  p_recover_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |-> final_status != 2'b00);

  p_done_attempts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> attempts != '0);

  p_evt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_count == {EW{1'b1}} && !evt_clr) |=> evt_count == {EW{1'b1}});

  p_evt_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> evt_count == '0);

endmodule

bind xfer_retry_ctl xfer_retry_ctl_chk #(.AW(AW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .eng_start(eng_start),
  .done(done), .recover_req(recover_req), .final_status(final_status),
  .attempts(attempts), .evt_clr(evt_clr), .evt_count(evt_count)
);

// File: tb/xfer_retry_ctl_test.sv
module xfer_retry_ctl_test;
  localparam int AW = 3, BW = 4, EW = 3;
  localparam int EVMAX = (1 << EW) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, recover_en = 0, eng_done = 0, evt_clr = 0;
  logic [AW-1:0] max_attempts = 0;
  logic [BW-1:0] backoff_cycles = 0;
  logic [1:0] eng_status = 0;
  logic req_ready, eng_start, done, recover_req;
  logic [1:0] final_status;
  logic [AW-1:0] attempts;
  logic [EW-1:0] evt_count;

  always #2 clk = ~clk;

  xfer_retry_ctl #(.AW(AW), .BW(BW), .EW(EW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .max_attempts(max_attempts), .backoff_cycles(backoff_cycles),
    .recover_en(recover_en), .eng_start(eng_start), .eng_done(eng_done),
    .eng_status(eng_status), .done(done), .final_status(final_status),
    .attempts(attempts), .recover_req(recover_req), .evt_clr(evt_clr),
    .evt_count(evt_count)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // phase: 0 idle, 1 start, 2 waiting, 3 gap, 4 recovery, 5 report
  int m_ph, m_att, m_lim, m_gap, m_gaplen, m_rec, m_fs, m_evt;
  bit spur = 0;
  int lat_cd = 0;
  int sq[$];
  int starts = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_att = 0; m_lim = 1; m_gap = 0; m_gaplen = 0;
      m_rec = 0; m_fs = 0; m_evt = 0;
    end else begin
      int nph;
      bit inc;
      nph = m_ph;
      inc = 0;
      if (m_ph == 0 && req_valid) begin
        m_att = 0;
        m_lim = (max_attempts == 0) ? 1 : int'(max_attempts);
        m_gaplen = int'(backoff_cycles);
        m_rec = int'(recover_en);
        nph = 1;
      end else if (m_ph == 1) begin
        m_att++; nph = 2;
      end else if (m_ph == 2 && eng_done) begin
        m_fs = int'(eng_status);
        if (eng_status == 0) nph = 5;
        else if (m_att >= m_lim) nph = m_rec ? 4 : 5;
        else begin nph = 3; m_gap = m_gaplen; inc = 1; end
      end else if (m_ph == 3) begin
        if (m_gap == 0) nph = 1; else m_gap--;
      end else if (m_ph == 4) begin
        inc = 1; nph = 5;
      end else if (m_ph == 5) nph = 0;
      if (evt_clr) m_evt = 0;
      else if (inc && m_evt < EVMAX) m_evt++;
      m_ph = nph;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_ph == 0), "R9 req_ready", req_ready, m_ph == 0);
      chk(eng_start == (m_ph == 1), "R4 eng_start", eng_start, m_ph == 1);
      chk(done == (m_ph == 5), "R3 done", done, m_ph == 5);
      chk(recover_req == (m_ph == 4), "R6 recover_req", recover_req, m_ph == 4);
      chk(int'(final_status) == m_fs, "R5 final_status", final_status, m_fs);
      chk(int'(attempts) == m_att, "R5 attempts", attempts, m_att);
      chk(int'(evt_count) == m_evt, "R7 evt_count", evt_count, m_evt);
    end
    if (eng_start) starts++;
    eng_done = 0;
    if (spur) begin
      eng_done = 1; eng_status = 2'b01;
    end else if (lat_cd == 1) begin
      eng_done = 1;
      eng_status = sq.size() > 0 ? 2'(sq.pop_front()) : 2'b00;
    end
    if (lat_cd > 0) lat_cd--;
    if (eng_start) lat_cd = 3;
  end

  task automatic run(input int ma, input int b, input int rec, input int hold);
    @(negedge clk);
    max_attempts = AW'(ma); backoff_cycles = BW'(b); recover_en = rec[0];
    req_valid = 1;
    @(negedge clk);
    chk(eng_start == 1 && req_ready == 0, "R2 start after accept", eng_start, 1);
    repeat (hold) @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 300; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && eng_start == 0 && done == 0 && recover_req == 0,
        "R1 reset controls", req_ready, 1);
    chk(final_status == 0 && attempts == 0 && evt_count == 0,
        "R1 reset values", evt_count, 0);
    rst_n = 1;

    sq = '{0};
    run(3, 2, 1, 0);
    chk(final_status == 0 && attempts == 1, "R3 first-try ok", attempts, 1);

    sq = '{1, 0};
    run(3, 2, 1, 0);
    chk(final_status == 0 && attempts == 2, "R4 retry then ok", attempts, 2);

    sq = '{2, 1, 2};
    run(3, 2, 1, 0);
    chk(final_status == 2 && attempts == 3, "R5 limit reached", attempts, 3);
    chk(evt_count == 4, "R6 R7 retries and recovery counted", evt_count, 4);

    sq = '{1, 3, 1};
    run(3, 0, 0, 0);
    chk(final_status == 1 && evt_count == 6, "R6 no escalation", evt_count, 6);

    sq = '{2};
    run(0, 1, 1, 0);
    chk(attempts == 1 && final_status == 2, "R5 zero limit is one", attempts, 1);
    chk(evt_count == EVMAX, "R7 reaches max", evt_count, EVMAX);

    sq = '{1, 1};
    run(2, 1, 1, 0);
    chk(evt_count == EVMAX, "R7 saturates", evt_count, EVMAX);

    starts = 0;
    sq = '{1, 0};
    run(3, 5, 0, 5);
    chk(attempts == 2, "R9 busy request refused", attempts, 2);

    @(negedge clk); spur = 1;
    @(negedge clk); spur = 0;
    @(negedge clk);
    chk(done == 0 && final_status == 0 && req_ready == 1, "R10 stray completion",
        final_status, 0);

    evt_clr = 1;
    @(negedge clk);
    chk(evt_count == 0, "R8 clear", evt_count, 0);
    sq = '{1, 1, 0};
    run(3, 1, 1, 0);
    chk(evt_count == 0, "R8 clear over increment", evt_count, 0);
    evt_clr = 0;
    sq = '{1, 0};
    run(3, 1, 1, 0);
    chk(evt_count == 1, "R7 count after clear", evt_count, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule